// File: doc/BRIEF.md
# Manchester Line Encoder with Start Preamble

This block turns a serial NRZ bit stream into a complementary pair of Manchester-coded line outputs. One oversampling clock drives it. A rate input picks 16 or 32 of those clocks per bit period. A phase counter runs freely from reset and marks bit boundaries and mid-bit points. The block drives a 1X bit clock output with a 50% duty cycle. An upstream shift register uses the falling edge of that clock to present each NRZ bit.

The active-low clear-to-send input gates transmission. While it is high, both line outputs rest high and the bit clock stays low. Suppose the block is idle and clear-to-send is low at a bit boundary. The block then sends eight Manchester zero bits, followed by a three-bit sync pulse that breaks the Manchester rules. After that it encodes user data with no framing until clear-to-send rises again. Once the rise is seen, the block sends one more bit carrying the last sampled value and then returns to idle.

Top module: `manchester_tx`

## Requirements
- R1: A bit period lasts 16 clocks when `rateSlow` is 0 and 32 clocks when `rateSlow` is 1. The phase counter starts at 0 on the first clock after reset. The last clock of a period is the clock in which the counter holds the period length minus one.
- R2: While the block is idle, `lineOne` and `lineZero` are both 1 and `bitClk` is 0.
- R3: If the block is idle and `ctsN` is 0 at the last clock of a bit period, the next eight bit periods each carry a Manchester zero. A zero means `lineOne` is 0 for the first half of the period and 1 for the second half.
- R4: The three bit periods after the preamble form the sync pulse. `lineOne` is 1 for the first 1.5 periods and 0 for the last 1.5 periods.
- R5: `bitClk` runs from the start of the third sync bit onward. It is 1 in the first half of each bit period and 0 in the second half. It is forced to 0 in any clock that follows a clock in which `ctsN` was 1.
- R6: `nrzIn` is sampled on the clock edge where `bitClk` falls, in the middle of each period in which `bitClk` runs. The sampled value is sent in the next bit period. A 1 puts `lineOne` high then low; a 0 puts it low then high.
- R7: Whenever the block is not idle, `lineZero` is the complement of `lineOne`.
- R8: Data bits follow one another with no gaps, framing or parity for as long as `ctsN` stays 0 at each bit boundary.
- R9: Suppose `ctsN` is 1 at the last clock of a preamble, sync or data period. The next period carries the last sampled data value. The block is idle from the period after that. Clear-to-send is not examined during that final period.
- R10: Reset is synchronous and active low. It clears the phase counter and the sampled data, and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rstN | input | 1 | Synchronous reset, active low |
| rateSlow | input | 1 | 0: 16 clocks per bit, 1: 32 clocks per bit |
| ctsN | input | 1 | Clear-to-send, active low |
| nrzIn | input | 1 | Serial NRZ data from the upstream source |
| bitClk | output | 1 | 1X bit clock, data sampled on its falling edge |
| lineOne | output | 1 | Manchester line output, true polarity |
| lineZero | output | 1 | Complement line output |

## Verification
A slip in the phase counter shows at the ports within one bit period. The mid-bit transition of `lineOne` moves, and so does the falling edge of `bitClk`. A wrong preamble or sync count shifts where the first data bit appears by whole bit periods, and that mismatch is visible on the first clock of the shifted period. If the sample register or the transmit bit register is corrupted, the wrong level shows on `lineOne` in the very next bit period. The bench compares every output on every clock against a behavioural model, so each such fault is reported in the clock where it first appears.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SYNC,
    ST_DATA,
    ST_DRAIN
  } txState_e;

  typedef enum logic [2:0] {
    LS_IDLE,
    LS_ZERO,
    LS_HIGH,
    LS_HIGHLOW,
    LS_LOW,
    LS_DATA
  } lineSel_e;

  typedef struct packed {
    lineSel_e lineSel;
    logic     firstHalf;
    logic     sample;
    logic     loadTx;
    logic     clkGate;
  } txStrobe_t;

endpackage

// File: rtl/mtx_ctrl.sv
module mtx_ctrl
  import mtx_pkg::*;
#(
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 32,
  parameter int PRE_BITS = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rateSlow,
  input  logic      ctsN,
  output txStrobe_t strb
);

  localparam int PH_W      = $clog2(SLOW_DIV);
  localparam int CNT_W     = $clog2((PRE_BITS > 4) ? PRE_BITS : 4);
  localparam int SYNC_LAST = 2;

  logic [PH_W-1:0]  ph;
  logic [PH_W:0]    phExt;
  logic [PH_W:0]    divNow;
  logic [PH_W:0]    halfNow;
  logic             bndy;
  logic             midPt;
  logic             ckOn;
  logic             ctsQ;
  txState_e         state, stNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             loadNext;

  assign divNow  = rateSlow ? (PH_W+1)'(SLOW_DIV) : (PH_W+1)'(FAST_DIV);
  assign halfNow = divNow >> 1;
  assign phExt   = {1'b0, ph};
  assign bndy    = (phExt >= divNow - 1'b1);
  assign midPt   = (phExt == halfNow - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ph    <= '0;
      ctsQ  <= 1'b1;
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      ph    <= bndy ? '0 : ph + 1'b1;
      ctsQ  <= ctsN;
      state <= stNext;
      cnt   <= cntNext;
    end
  end

  always_comb begin
    stNext   = state;
    cntNext  = cnt;
    loadNext = 1'b0;
    if (bndy) begin
      case (state)
        ST_IDLE: begin
          if (!ctsN) begin
            stNext  = ST_PRE;
            cntNext = '0;
          end
        end
        ST_PRE, ST_SYNC, ST_DATA: begin
          if (ctsN) begin
            stNext   = ST_DRAIN;
            loadNext = 1'b1;
          end else if (state == ST_PRE) begin
            if (cnt == CNT_W'(PRE_BITS - 1)) begin
              stNext  = ST_SYNC;
              cntNext = '0;
            end else begin
              cntNext = cnt + 1'b1;
            end
          end else if (state == ST_SYNC) begin
            if (cnt == CNT_W'(SYNC_LAST)) begin
              stNext   = ST_DATA;
              loadNext = 1'b1;
            end else begin
              cntNext = cnt + 1'b1;
            end
          end else begin
            loadNext = 1'b1;
          end
        end
        default: stNext = ST_IDLE;
      endcase
    end
  end

  assign ckOn = ((state == ST_SYNC) && (cnt == CNT_W'(SYNC_LAST))) || (state == ST_DATA);

  always_comb begin
    case (state)
      ST_PRE:  strb.lineSel = LS_ZERO;
      ST_SYNC: begin
        if (cnt == '0)                         strb.lineSel = LS_HIGH;
        else if (cnt == CNT_W'(SYNC_LAST - 1)) strb.lineSel = LS_HIGHLOW;
        else                                   strb.lineSel = LS_LOW;
      end
      ST_DATA, ST_DRAIN: strb.lineSel = LS_DATA;
      default: strb.lineSel = LS_IDLE;
    endcase
  end

  assign strb.firstHalf = (phExt < halfNow);
  assign strb.sample    = midPt && ckOn;
  assign strb.loadTx    = loadNext;
  assign strb.clkGate   = ckOn && !ctsQ;

  // the phase never reaches the selected period length
  assert_phase_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    phExt < divNow);

  // state moves only at bit boundaries
  assert_state_at_bndy_R3: assert property (@(posedge clk) disable iff (!rstN)
    !bndy |=> $stable(state));

  // the preamble hands over to the sync pulse after its last bit
  assert_pre_to_sync_R4: assert property (@(posedge clk) disable iff (!rstN)
    (bndy && state == ST_PRE && cnt == CNT_W'(PRE_BITS - 1) && !ctsN) |=> state == ST_SYNC);

  // the final bit always leads to idle
  assert_drain_ends_R9: assert property (@(posedge clk) disable iff (!rstN)
    (bndy && state == ST_DRAIN) |=> state == ST_IDLE);

  // a high clear-to-send stops the bit clock on the next clock
  assert_gate_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctsN |=> !strb.clkGate);

endmodule

// File: rtl/mtx_datapath.sv
module mtx_datapath
  import mtx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  txStrobe_t strb,
  input  logic      nrzIn,
  output logic      bitClk,
  output logic      lineOne,
  output logic      lineZero
);

  logic holdBit;
  logic txBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdBit <= 1'b0;
      txBit   <= 1'b0;
    end else begin
      if (strb.sample) holdBit <= nrzIn;
      if (strb.loadTx) txBit   <= holdBit;
    end
  end

  always_comb begin
    case (strb.lineSel)
      LS_ZERO:    lineOne = !strb.firstHalf;
      LS_HIGH:    lineOne = 1'b1;
      LS_HIGHLOW: lineOne = strb.firstHalf;
      LS_LOW:     lineOne = 1'b0;
      LS_DATA:    lineOne = strb.firstHalf ? txBit : !txBit;
      default:    lineOne = 1'b1;
    endcase
  end

  assign lineZero = (strb.lineSel == LS_IDLE) ? 1'b1 : !lineOne;
  assign bitClk   = strb.clkGate && strb.firstHalf;

  // sampling at mid-bit and loading at the boundary never coincide
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.sample && strb.loadTx));

  // the transmitted bit only changes on a load strobe
  assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadTx |=> $stable(txBit));

  // the two line outputs differ while the bit clock runs
  assert_complement_R7: assert property (@(posedge clk) disable iff (!rstN)
    bitClk |-> (lineOne != lineZero));

endmodule

// File: rtl/manchester_tx.sv
module manchester_tx
  import mtx_pkg::*;
#(
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 32,
  parameter int PRE_BITS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic rateSlow,
  input  logic ctsN,
  input  logic nrzIn,
  output logic bitClk,
  output logic lineOne,
  output logic lineZero
);

  txStrobe_t strb;

  mtx_ctrl #(
    .FAST_DIV(FAST_DIV),
    .SLOW_DIV(SLOW_DIV),
    .PRE_BITS(PRE_BITS)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .rateSlow(rateSlow),
    .ctsN(ctsN),
    .strb(strb)
  );

  mtx_datapath u_dp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .nrzIn(nrzIn),
    .bitClk(bitClk),
    .lineOne(lineOne),
    .lineZero(lineZero)
  );

endmodule

// File: tb/manchester_tx_bench.sv
`timescale 1ns/1ps
module manchester_tx_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rateSlow = 1'b0;
  logic ctsN = 1'b1;
  logic nrzIn = 1'b0;
  logic bitClk, lineOne, lineZero;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int lastRise = -1;
  logic prevBitClk = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  bit done = 0;

  always #10 clk = ~clk;

  manchester_tx u_manchester_tx (
    .clk(clk), .rstN(rstN), .rateSlow(rateSlow), .ctsN(ctsN),
    .nrzIn(nrzIn), .bitClk(bitClk), .lineOne(lineOne), .lineZero(lineZero)
  );

  // behavioural model: 0 idle, 1 preamble, 2 sync, 3 data, 4 last bit
  int mPh, mSt, mCnt;
  logic mHold, mTx, mCtsQ;

  function automatic int periodLen();
    return rateSlow ? 32 : 16;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mSt = 0; mCnt = 0; mHold = 0; mTx = 0; mCtsQ = 1;
    end else begin
      int len;
      bit bnd, midE, ckRun;
      len   = periodLen();
      bnd   = (mPh >= len - 1);
      midE  = (mPh == len / 2 - 1);
      ckRun = (mSt == 2 && mCnt == 2) || mSt == 3;
      if (midE && ckRun) mHold = nrzIn;
      if (bnd) begin
        if (mSt == 0) begin
          if (!ctsN) begin mSt = 1; mCnt = 0; end
        end else if (mSt == 4) begin
          mSt = 0;
        end else if (ctsN) begin
          mSt = 4; mTx = mHold;
        end else if (mSt == 1) begin
          if (mCnt == 7) begin mSt = 2; mCnt = 0; end else mCnt++;
        end else if (mSt == 2) begin
          if (mCnt == 2) begin mSt = 3; mTx = mHold; end else mCnt++;
        end else begin
          mTx = mHold;
        end
      end
      mPh = bnd ? 0 : mPh + 1;
      mCtsQ = ctsN;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    cyc++;
    if (rstN && !done) begin
      bit fh, expClk, expOne, expZero;
      string tag;
      fh = (mPh < periodLen() / 2);
      expClk = ((mSt == 2 && mCnt == 2) || mSt == 3) && !mCtsQ && fh;
      case (mSt)
        1: begin expOne = !fh; tag = "R3"; end
        2: begin expOne = (mCnt == 0) ? 1'b1 : (mCnt == 1) ? fh : 1'b0; tag = "R4"; end
        3: begin expOne = fh ? mTx : !mTx; tag = "R6/R8"; end
        4: begin expOne = fh ? mTx : !mTx; tag = "R9"; end
        default: begin expOne = 1'b1; tag = "R2"; end
      endcase
      expZero = (mSt == 0) ? 1'b1 : !expOne;
      check(lineOne == expOne, {tag, " lineOne"}, lineOne, expOne);
      check(lineZero == expZero, {tag, " lineZero"}, lineZero, expZero);
      check(bitClk == expClk, "R5 bitClk", bitClk, expClk);
      if (mSt != 0) check(lineZero != lineOne, "R7 complement", lineZero, !lineOne);
      if (bitClk && !prevBitClk) begin
        if (lastRise >= 0 && (cyc - lastRise) < 48)
          check((cyc - lastRise) == periodLen(), "R1 bit period", cyc - lastRise, periodLen());
        lastRise = cyc;
      end
      prevBitClk = bitClk;
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      nrzIn = lfsr[0];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    run(4);
    @(negedge clk);
    rstN = 1'b1;
    #3;
    // R10: reset leaves the block idle
    check(lineOne == 1'b1 && lineZero == 1'b1, "R10 idle lines", {lineOne, lineZero}, 3);
    check(bitClk == 1'b0, "R10 bitClk", bitClk, 0);
    run(37);
    ctsN = 1'b0; run(16 * 24);
    ctsN = 1'b1; run(16 * 4);
    rateSlow = 1'b1; run(50);
    ctsN = 1'b0; run(32 * 18);
    ctsN = 1'b1; run(32 * 4);
    // stop during the preamble
    ctsN = 1'b0; run(32 * 3);
    ctsN = 1'b1; run(32 * 3);
    // clear-to-send drops again during the final bit
    ctsN = 1'b0; run(32 * 16);
    ctsN = 1'b1; run(10);
    ctsN = 1'b0; run(40);
    run(32 * 14);
    ctsN = 1'b1; run(32 * 4);
    rateSlow = 1'b0; run(20);
    ctsN = 1'b0; run(16 * 30);
    ctsN = 1'b1; run(16 * 4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule